// File: doc/BRIEF.md
# Cascadable Presettable 4-Bit Up-Counter

This block is a synchronous up-counter whose state bits all change together on the rising clock edge. Two build-time parameters shape it. One picks the modulus: decade, counting 0 to 9, or binary, counting 0 to 15. The other picks how the active-low clear acts: asynchronously, at once, or synchronously, at the next clock edge. The counter can be preset at any edge from a parallel data input through an active-low load. It advances only when both of its count enables are high.

The carry output goes high while the count sits at its maximum and the trickle enable is high. The parallel enable has no effect on the carry. Wider synchronous counters are built by chaining stages without extra gates. Each stage's carry drives the next stage's trickle enable, and every stage shares the clock and the parallel enable.

The synchronous-clear build can also shorten the count length. A decode of the count outputs is fed back to the clear input, and the counter then restarts from zero at the next edge.

Top module: `lookahead_counter`

## Requirements
- R1: Changes on the load input or either enable between rising clock edges leave the stored count unchanged. Only the levels present at the edge decide the next state.
- R2: When loadN is low and clear is inactive at a rising edge, the count takes dataIn whatever the levels of enP and enT.
- R3: In the synchronous-clear build, clrN low at a rising edge makes the count 0 after that edge. This overrides load and both enables.
- R4: In the asynchronous-clear build, clrN low forces the count to 0 at once, without waiting for a clock edge, and holds it at 0 while clrN stays low.
- R5: With clear and load inactive and enP and enT both high, a rising edge raises the count by one when it is below the maximum.
- R6: With clear and load inactive and either enable low, a rising edge leaves the count unchanged.
- R7: A counting edge at the maximum wraps the count to 0. The maximum is 9 when DECADE=1 and 15 when DECADE=0.
- R8: In the decade build, a count of 10 to 15 (reachable only by load) goes to 0 on the next counting edge, and the carry stays low for those values.
- R9: rco is 1 exactly when enT is 1 and the count equals the maximum. enP has no effect on rco.
- R10: Three binary stages chained carry-to-enT, with a shared enP, count as one 12-bit counter. The last stage's carry is high only at 4095.
- R11: In a synchronous-clear binary stage whose clear is driven low by a decode of count 11, with both enables high, the count runs 0 to 11 and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on the rising edge |
| clrN | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_CLR |
| loadN | input | 1 | Active-low synchronous parallel load |
| enP | input | 1 | Parallel count enable; gates counting only |
| enT | input | 1 | Trickle count enable; gates counting and the carry |
| dataIn | input | CNT_W | Parallel preset value |
| cntOut | output | CNT_W | Current count |
| rco | output | 1 | Ripple carry output: enT high and count at its maximum |

## Verification
A wrong next-state decision shows on cntOut one clock after the edge that made it, and it stays visible because the count is held until the next edge. A wrong carry decode shows with no delay, in the cycle where the count reaches its maximum. In a chain, it shows one cycle later as a missed or extra step in the next stage. Errors in the decade wrap and in the out-of-range recovery only show up at the few counts from 9 to 15. For that reason, directed loads place the count there as well as random stimulus. The truncated-count loop turns a clear-timing fault into a wrong period within twelve cycles.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  // Strobes from the control decode to the count register
  typedef struct packed {
    logic clrSync;  // synchronous clear at the next edge
    logic load;     // take the parallel value
    logic inc;      // advance by one
  } ctrStrobe_t;
endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
  import ctr_pkg::*;
#(
  parameter int          CNT_W     = 4,
  parameter bit          ASYNC_CLR = 1'b1,
  parameter logic [CNT_W-1:0] MAX_VAL = CNT_W'(9)
) (
  input  logic             clrN,
  input  logic             loadN,
  input  logic             enP,
  input  logic             enT,
  input  logic [CNT_W-1:0] cnt,
  output ctrStrobe_t       strobe,
  output logic             rco
);
  logic clrReq;

  generate
    if (ASYNC_CLR) begin : g_asyncClr
      // the register handles clear itself
      assign clrReq = 1'b0;
    end else begin : g_syncClr
      assign clrReq = ~clrN;
    end
  endgenerate

  always_comb begin
    strobe.clrSync = clrReq;
    strobe.load    = ~loadN;
    strobe.inc     = enP & enT;
  end

  // Carry depends only on state and the trickle enable
  assign rco = enT && (cnt == MAX_VAL);
endmodule

// File: rtl/ctr_dp.sv
module ctr_dp
  import ctr_pkg::*;
#(
  parameter int          CNT_W     = 4,
  parameter bit          ASYNC_CLR = 1'b1,
  parameter logic [CNT_W-1:0] MAX_VAL = CNT_W'(9)
) (
  input  logic             clk,
  input  logic             clrN,
  input  ctrStrobe_t       strobe,
  input  logic [CNT_W-1:0] dataIn,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] nextCnt;
  logic             atTop;

  // At or beyond the top value, the next count step wraps to zero
  assign atTop = (cnt >= MAX_VAL);

  always_comb begin
    if (strobe.clrSync)   nextCnt = '0;
    else if (strobe.load) nextCnt = dataIn;
    else if (strobe.inc)  nextCnt = atTop ? '0 : CNT_W'(cnt + 1'b1);
    else                  nextCnt = cnt;
  end

  generate
    if (ASYNC_CLR) begin : g_asyncReg
      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN) cnt <= '0;
        else       cnt <= nextCnt;
      end

      AST_ASYNC_CLEAR_ZERO: assert property (@(posedge clk)
        !clrN |-> cnt == '0) else $error("async clear"); // R4
    end else begin : g_syncReg
      always_ff @(posedge clk) cnt <= nextCnt;

      AST_SYNC_CLEAR_WINS: assert property (@(posedge clk)
        strobe.clrSync |=> cnt == '0) else $error("sync clear"); // R3
    end
  endgenerate

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!clrN)
    strobe.load |=> cnt == $past(dataIn)) else $error("load"); // R2

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!clrN)
    !strobe.load && strobe.inc && cnt < MAX_VAL |=> cnt == CNT_W'($past(cnt) + 1'b1))
    else $error("step"); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clrN)
    !strobe.load && !strobe.inc |=> $stable(cnt)) else $error("hold"); // R6

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clrN)
    !strobe.load && strobe.inc && cnt >= MAX_VAL |=> cnt == '0) else $error("wrap"); // R7
endmodule

// File: rtl/lookahead_counter.sv
module lookahead_counter
  import ctr_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             loadN,
  input  logic             enP,
  input  logic             enT,
  input  logic [CNT_W-1:0] dataIn,
  output logic [CNT_W-1:0] cntOut,
  output logic             rco
);
  localparam logic [CNT_W-1:0] MAX_VAL = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

  ctrStrobe_t strobe;

  ctr_ctrl #(.CNT_W(CNT_W), .ASYNC_CLR(ASYNC_CLR), .MAX_VAL(MAX_VAL)) u_ctrl (
    .clrN(clrN), .loadN(loadN), .enP(enP), .enT(enT),
    .cnt(cntOut), .strobe(strobe), .rco(rco)
  );

  ctr_dp #(.CNT_W(CNT_W), .ASYNC_CLR(ASYNC_CLR), .MAX_VAL(MAX_VAL)) u_dp (
    .clk(clk), .clrN(clrN), .strobe(strobe), .dataIn(dataIn), .cnt(cntOut)
  );

  AST_CARRY_NEEDS_ENT: assert property (@(posedge clk) disable iff (!clrN)
    !enT |-> !rco) else $error("carry without enT"); // R9

  AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (!clrN)
    enT && cntOut == MAX_VAL |-> rco) else $error("carry missing"); // R9
endmodule

// File: tb/sim_lookahead_counter.sv
module sim_lookahead_counter;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  logic clrN = 1'b0, loadN = 1'b1, enP = 1'b0, enT = 1'b0;
  logic [3:0] dIn = '0;
  logic [3:0] q [4];
  logic       r [4];
  logic [3:0] expQ [4];
  localparam bit IS_DEC [4] = '{1'b1, 1'b1, 1'b0, 1'b0};

  // u0 decade/async, u1 decade/sync, u2 binary/async, u3 binary/sync
  lookahead_counter #(.DECADE(1), .ASYNC_CLR(1)) u0 (.clk(clk), .clrN(clrN), .loadN(loadN),
    .enP(enP), .enT(enT), .dataIn(dIn), .cntOut(q[0]), .rco(r[0]));
  lookahead_counter #(.DECADE(1), .ASYNC_CLR(0)) u1 (.clk(clk), .clrN(clrN), .loadN(loadN),
    .enP(enP), .enT(enT), .dataIn(dIn), .cntOut(q[1]), .rco(r[1]));
  lookahead_counter #(.DECADE(0), .ASYNC_CLR(1)) u2 (.clk(clk), .clrN(clrN), .loadN(loadN),
    .enP(enP), .enT(enT), .dataIn(dIn), .cntOut(q[2]), .rco(r[2]));
  lookahead_counter #(.DECADE(0), .ASYNC_CLR(0)) u3 (.clk(clk), .clrN(clrN), .loadN(loadN),
    .enP(enP), .enT(enT), .dataIn(dIn), .cntOut(q[3]), .rco(r[3]));

  // Three-stage chain for R10
  logic chClrN = 1'b0, chEn = 1'b0;
  logic [3:0] cq0, cq1, cq2;
  logic cr0, cr1, cr2;
  lookahead_counter #(.DECADE(0), .ASYNC_CLR(0)) uc0 (.clk(clk), .clrN(chClrN), .loadN(1'b1),
    .enP(chEn), .enT(1'b1), .dataIn(4'd0), .cntOut(cq0), .rco(cr0));
  lookahead_counter #(.DECADE(0), .ASYNC_CLR(0)) uc1 (.clk(clk), .clrN(chClrN), .loadN(1'b1),
    .enP(chEn), .enT(cr0), .dataIn(4'd0), .cntOut(cq1), .rco(cr1));
  lookahead_counter #(.DECADE(0), .ASYNC_CLR(0)) uc2 (.clk(clk), .clrN(chClrN), .loadN(1'b1),
    .enP(chEn), .enT(cr1), .dataIn(4'd0), .cntOut(cq2), .rco(cr2));

  // Truncated counter for R11: clear fed back from a decode of 11
  logic tClrN = 1'b0;
  logic [3:0] tq;
  logic tr, fbClrN;
  assign fbClrN = tClrN & (tq != 4'd11);
  lookahead_counter #(.DECADE(0), .ASYNC_CLR(0)) ut (.clk(clk), .clrN(fbClrN), .loadN(1'b1),
    .enP(1'b1), .enT(1'b1), .dataIn(4'd0), .cntOut(tq), .rco(tr));

  function automatic logic [3:0] refNext(logic [3:0] c, bit dec, logic cl, logic ld,
                                         logic p, logic t, logic [3:0] d);
    logic [3:0] top = dec ? 4'd9 : 4'd15;
    if (!cl) return 4'd0;
    if (!ld) return d;
    if (p && t) return (c >= top) ? 4'd0 : c + 4'd1;
    return c;
  endfunction

  function automatic logic refRco(logic [3:0] c, bit dec, logic t);
    return t && (c == (dec ? 4'd9 : 4'd15));
  endfunction

  task automatic chk(string tag, int act, int exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: apply inputs, pass one rising edge, check at the next falling edge
  task automatic step(string tag, logic cl, logic ld, logic p, logic t, logic [3:0] d,
                      bit glitch = 1'b0);
    clrN = cl; loadN = ld; enP = p; enT = t; dIn = d;
    if (glitch) begin
      #1 loadN = ~ld; enP = ~p; enT = ~t;
      #1 loadN = ld;  enP = p;  enT = t;
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      expQ[i] = refNext(expQ[i], IS_DEC[i], cl, ld, p, t, d);
      chk($sformatf("%s cnt u%0d", tag, i), q[i], expQ[i]);
      chk($sformatf("%s rco u%0d", tag, i), r[i], refRco(expQ[i], IS_DEC[i], t));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [11:0] wide;
    logic [3:0]  tExp;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) expQ[i] = 4'd0;
    @(negedge clk);
    step("reset R4", 1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    step("load R2", 1'b1, 1'b0, 1'b0, 1'b0, 4'd7);
    // R4: asynchronous clear acts before any edge; the synchronous build waits
    clrN = 1'b0;
    #1;
    chk("R4 immediate u0", q[0], 0);
    chk("R4 immediate u2", q[2], 0);
    chk("R3 waits u1", q[1], 7);
    chk("R3 waits u3", q[3], 7);
    @(negedge clk);
    for (int i = 0; i < 4; i++) expQ[i] = 4'd0;
    step("load R2 enables high", 1'b1, 1'b0, 1'b1, 1'b1, 4'd5);
    step("sync clear R3", 1'b0, 1'b0, 1'b1, 1'b1, 4'd3);
    step("load R2", 1'b1, 1'b0, 1'b0, 1'b0, 4'd4);
    step("hold R6 enT low", 1'b1, 1'b1, 1'b1, 1'b0, 4'd0);
    step("hold R6 enP low", 1'b1, 1'b1, 1'b0, 1'b1, 4'd0);
    step("glitch R1", 1'b1, 1'b1, 1'b0, 1'b0, 4'd2, 1'b1);
    step("count R5", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    step("load 9 R9", 1'b1, 1'b0, 1'b0, 1'b1, 4'd9);
    step("enP free R9", 1'b1, 1'b1, 1'b0, 1'b1, 4'd0);
    step("enT gates R9", 1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    step("wrap R7", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    step("load 15 R8", 1'b1, 1'b0, 1'b0, 1'b1, 4'd15);
    step("wrap R7 R8", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    step("load 12 R8", 1'b1, 1'b0, 1'b0, 1'b1, 4'd12);
    step("recover R8", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    for (int k = 0; k < 600; k++) begin
      step("random R5", ($urandom % 20) != 0, ($urandom % 7) != 0,
           ($urandom % 5) != 0, ($urandom % 5) != 0, 4'($urandom), ($urandom % 9) == 0);
    end

    // Chain (R10) and truncated count (R11)
    chClrN = 1'b0; tClrN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chClrN = 1'b1; tClrN = 1'b1;
    wide = '0; tExp = '0;
    chk("R10 chain reset", {cq2, cq1, cq0}, 0);
    chk("R11 trunc reset", tq, 0);
    for (int k = 0; k < 5000; k++) begin
      chEn = ($urandom % 10) != 0;
      @(posedge clk);
      @(negedge clk);
      if (chEn) wide = wide + 12'd1;
      tExp = (tExp == 4'd11) ? 4'd0 : tExp + 4'd1;
      chk("R10 wide count", {cq2, cq1, cq0}, wide);
      chk("R10 top carry", cr2, (wide == 12'hFFF) ? 1 : 0);
      chk("R11 short count", tq, tExp);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule